// File: doc/BRIEF.md
# Indirect PHY Register Viewport

This block places a byte-wide bank of PHY-style configuration registers behind one 32-bit command word on a simple register bus. Software does not address the bank directly. It writes a single command that carries a target index, a direction, a data byte, a port number and a start flag. The block carries out that one access and reports the outcome in the same word.

A store copies the command's data byte into the chosen bank entry. A fetch places the chosen entry into a read-back byte of the command word. Either access finishes on the clock edge that accepts the command. The start flag is then already clear, so software that polls it sees completion on its first read.

The bank has 256 entries, so every 8-bit index is valid. Four entries at the bottom of the bank come out of reset holding identifier bytes. All other entries reset to zero.

Top module: `phyvp_bridge`

## Requirements
- R1: After reset, `rdata` reads 0x0800_0000. Bit 27 (link-sync flag) is 1 and every other bit is 0.
- R2: After reset, bank entries 0x00, 0x01, 0x02 and 0x03 hold 0x24, 0x04, 0x04 and 0x00. A fetch of each returns that value in bits 15:8.
- R3: An accepted write copies `wdata` bits 7:0 (data byte), 23:16 (index), 26:24 (port) and 29 (direction, 1 = store, 0 = fetch) into the command word. The new values are visible on `rdata` after the accepting edge.
- R4: Bit 31 (wake flag) never reads back as 1, even when it is written as 1.
- R5: An accepted write with bit 30 (start) = 1 and bit 29 = 1 stores bits 7:0 into the bank entry that bits 23:16 select.
- R6: An accepted write with bit 30 = 1 and bit 29 = 0 loads the bank entry that bits 23:16 select into bits 15:8. The value is visible after the accepting edge.
- R7: Bit 30 reads 0 after every accepted write, because each access completes on its accepting edge.
- R8: A write is accepted only when `sel` = 1, `wr_en` = 1 and `be` = 4'hF. Any other write leaves both the command word and the bank unchanged.
- R9: An accepted write with bit 30 = 0 changes no bank entry and leaves bits 15:8 unchanged. Bit 28 and bit 27 are not writable: bit 28 stays 0 and bit 27 stays 1.
- R10: After reset, every bank entry above 0x03 holds 0x00. Entries written by stores, for example the scratch entry 0x16, keep their data until the next store to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Selects the command word for this bus cycle |
| wr_en | input | 1 | Write strobe |
| be | input | 4 | Byte lanes; only 4'hF is accepted |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current command word |

## Verification
Every result is due on the first rising edge after the bus cycle that presents the write: the updated command word, the read-back byte, the cleared start flag and the bank store. A fetch that follows a store therefore sees the stored byte one cycle later. The driver presents each write just after a rising edge and queues the expected word, tagged with the cycle count the next edge will reach. The monitor samples `rdata` on the falling edge and compares only entries whose due cycle has arrived. Ignored writes are checked in the same way, and a fetch of the entry they targeted follows them to show that the bank was not touched.

// File: rtl/phyvp_pkg.sv
package phyvp_pkg;

    localparam int BANK_AW = 8;
    localparam int BANK_DW = 8;
    localparam int BANK_DEPTH = 1 << BANK_AW;
    localparam int CMD_W = 32;

    // Software-writable positions: data byte, index, port, direction, start, wake
    localparam logic [CMD_W-1:0] WR_MASK  = 32'hE7FF_00FF;
    localparam logic [CMD_W-1:0] CMD_RST  = 32'h0800_0000;

    typedef struct packed {
        logic               wake;   // 31
        logic               start;  // 30
        logic               dir;    // 29, 1 = store
        logic               rsvd;   // 28
        logic               sync;   // 27
        logic [2:0]         port;   // 26:24
        logic [BANK_AW-1:0] idx;    // 23:16
        logic [BANK_DW-1:0] rbyte;  // 15:8
        logic [BANK_DW-1:0] wbyte;  // 7:0
    } cmd_t;

    function automatic logic [BANK_DW-1:0] bank_init(input int unsigned i);
        case (i)
            0: return 8'h24;
            1: return 8'h04;
            2: return 8'h04;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/phyvp_merge.sv
module phyvp_merge
    import phyvp_pkg::*;
(
    input  cmd_t               cur,
    input  logic [CMD_W-1:0]   wdata,
    output cmd_t               merged
);
    logic [CMD_W-1:0] raw;

    always_comb begin
        raw = (CMD_W'(cur) & ~WR_MASK) | (wdata & WR_MASK);
        merged = cmd_t'(raw);
        merged.wake = 1'b0;
    end
endmodule

// File: rtl/phyvp_exec.sv
module phyvp_exec
    import phyvp_pkg::*;
(
    input  cmd_t                merged,
    input  logic                accept,
    input  logic [BANK_DW-1:0]  bank_rd,
    output cmd_t                done,
    output logic                bank_we,
    output logic [BANK_AW-1:0]  bank_wa,
    output logic [BANK_DW-1:0]  bank_wd
);
    always_comb begin
        done    = merged;
        bank_we = 1'b0;
        bank_wa = merged.idx;
        bank_wd = merged.wbyte;
        if (merged.start) begin
            if (merged.dir) begin
                bank_we = accept;
            end else begin
                done.rbyte = bank_rd;
            end
            done.start = 1'b0;
        end
    end
endmodule

// File: rtl/phyvp_bank.sv
module phyvp_bank
    import phyvp_pkg::*;
#(
    parameter int AW = BANK_AW,
    parameter int DW = BANK_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DW'(bank_init(i));
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd = mem_q[ra];
endmodule

// File: rtl/phyvp_bridge.sv
module phyvp_bridge
    import phyvp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [3:0]        be,
    input  logic [CMD_W-1:0]  wdata,
    output logic [CMD_W-1:0]  rdata
);
    typedef struct packed {
        cmd_t cmd;
    } state_t;

    state_t st_d, st_q;

    logic               accept;
    cmd_t               merged;
    cmd_t               done;
    logic               bank_we;
    logic [BANK_AW-1:0] bank_wa;
    logic [BANK_DW-1:0] bank_wd;
    logic [BANK_DW-1:0] bank_rd;

    assign accept = sel & wr_en & (be == 4'hF);

    phyvp_merge u_merge (
        .cur    (st_q.cmd),
        .wdata  (wdata),
        .merged (merged)
    );

    phyvp_bank #(.AW(BANK_AW), .DW(BANK_DW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .wa    (bank_wa),
        .wd    (bank_wd),
        .ra    (merged.idx),
        .rd    (bank_rd)
    );

    phyvp_exec u_exec (
        .merged  (merged),
        .accept  (accept),
        .bank_rd (bank_rd),
        .done    (done),
        .bank_we (bank_we),
        .bank_wa (bank_wa),
        .bank_wd (bank_wd)
    );

    always_comb begin
        st_d = st_q;
        if (accept) st_d.cmd = done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cmd <= cmd_t'(CMD_RST);
        else        st_q <= st_d;
    end

    assign rdata = CMD_W'(st_q.cmd);
endmodule

// File: rtl/phyvp_chk.sv
module phyvp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        wr_en,
    input logic [3:0]  be,
    input logic [31:0] wdata,
    input logic [31:0] rdata
);
    logic acc;
    assign acc = sel && wr_en && (be == 4'hF);

    AST_WAKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[31]) else $error("wake flag read back as 1"); // R4

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[30]) else $error("start flag still set"); // R7

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[27] && !rdata[28]) else $error("fixed bits changed"); // R9

    AST_IGNORED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(rdata)) else $error("ignored write changed word"); // R8

    AST_FIELDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rdata[7:0] == $past(wdata[7:0])) && (rdata[26:16] == $past(wdata[26:16]))
                && (rdata[29] == $past(wdata[29]))) else $error("fields not taken"); // R3

    AST_NOSTART_RBYTE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !wdata[30] |=> rdata[15:8] == $past(rdata[15:8])) else $error("read byte moved"); // R9
endmodule

bind phyvp_bridge phyvp_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .wr_en (wr_en),
    .be    (be),
    .wdata (wdata),
    .rdata (rdata)
);

// File: tb/sim_phyvp_bridge.sv
module sim_phyvp_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  be = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    always #4 clk = ~clk; // 125 MHz

    phyvp_bridge u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
        .be(be), .wdata(wdata), .rdata(rdata)
    );

    typedef struct {
        logic [31:0] val;
        int          due;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    int          cyc = 0;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;
    logic [31:0] cmd_m;
    logic [7:0]  bank_m [256];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each queued result once its due cycle is reached
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rdata !== it.val) begin
                errors++;
                $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.val);
            end
        end
    end

    // Driver: one bus cycle, model update, expected item queued
    task automatic bus_wr(input logic s, input logic w, input logic [3:0] b,
                          input logic [31:0] d, input string tag);
        logic [31:0] v;
        sel = s; wr_en = w; be = b; wdata = d;
        if (s && w && b == 4'hF) begin
            v = (cmd_m & ~32'hE7FF_00FF) | (d & 32'hE7FF_00FF);
            v[31] = 1'b0;
            if (v[30]) begin
                if (v[29]) bank_m[v[23:16]] = v[7:0];
                else       v[15:8] = bank_m[v[23:16]];
                v[30] = 1'b0;
            end
            cmd_m = v;
        end
        exp_q.push_back('{val: cmd_m, due: cyc + 1, tag: tag});
        @(posedge clk);
        #2;
        sel = 1'b0; wr_en = 1'b0; be = 4'h0;
    endtask

    function automatic logic [31:0] mk(input logic wake, input logic start, input logic dir,
                                       input logic [2:0] port, input logic [7:0] idx,
                                       input logic [7:0] wb);
        return {wake, start, dir, 5'b0, idx, 8'h00, wb} | ({29'b0, port} << 24);
    endfunction

    task automatic fetch(input logic [7:0] idx, input string tag);
        bus_wr(1, 1, 4'hF, mk(0, 1, 0, 3'd0, idx, 8'h00), tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bank_m[i] = 8'h00;
        bank_m[0] = 8'h24; bank_m[1] = 8'h04; bank_m[2] = 8'h04; bank_m[3] = 8'h00;
        cmd_m = 32'h0800_0000;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rdata !== 32'h0800_0000) begin
            errors++;
            $display("FAIL R1: rdata=%h expected=%h", rdata, 32'h0800_0000);
        end
        @(posedge clk); #2;

        fetch(8'h00, "R2 id0");
        fetch(8'h01, "R2 id1");
        fetch(8'h02, "R2 id2");
        fetch(8'h03, "R2 id3");
        fetch(8'h80, "R10 zero 80");
        fetch(8'hFF, "R10 zero FF");
        bus_wr(1, 1, 4'hF, mk(0, 0, 1, 3'd5, 8'h16, 8'hA5), "R3 fields no start");
        bus_wr(1, 1, 4'hF, 32'h1000_0000 | mk(1, 0, 0, 3'd2, 8'h40, 8'h3C), "R4 R9 wake rsvd");
        bus_wr(1, 1, 4'hF, mk(0, 1, 1, 3'd1, 8'h16, 8'h5A), "R5 R7 store scratch");
        fetch(8'h16, "R6 fetch scratch");
        bus_wr(1, 1, 4'hF, mk(1, 1, 1, 3'd7, 8'hFF, 8'hC3), "R5 store top wake");
        bus_wr(1, 1, 4'hF, mk(0, 0, 1, 3'd0, 8'h16, 8'h11), "R9 no start keeps");
        fetch(8'hFF, "R6 fetch top");
        bus_wr(1, 1, 4'h7, mk(0, 1, 1, 3'd3, 8'h16, 8'h99), "R8 partial be");
        bus_wr(0, 1, 4'hF, mk(0, 1, 1, 3'd3, 8'h16, 8'h77), "R8 sel low");
        bus_wr(1, 0, 4'hF, mk(0, 1, 1, 3'd3, 8'h16, 8'h66), "R8 no strobe");
        fetch(8'h16, "R8 R10 scratch kept");
        fetch(8'h00, "R2 id0 kept");
        for (int k = 0; k < 8; k++) begin
            bus_wr(1, 1, 4'hF, mk(0, 1, 1, 3'(k), 8'(8'h20 + k), 8'(8'h10 * k + 3)), "R5 burst store");
        end
        for (int k = 0; k < 8; k++) begin
            fetch(8'(8'h20 + k), "R6 burst fetch");
        end
        repeat (3) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: rdata=%h expected=done", rdata);
        finish_run();
    end
endmodule